// File: doc/BRIEF.md
# Single-Line Blocking Instruction Cache

This block is an instruction cache for a pipelined processor. It keeps exactly one line of four 32-bit words, together with that line's tag and a valid flag. Every cycle the processor presents a fetch address. If the address lies in the stored line, the cache returns the selected word with no delay.

If the address is not in the stored line, the cache asks main memory for the whole line. It holds the pipeline stall high until memory signals that the line is ready. The line arrives as a single 128-bit transfer. It is written into the cache in the cycle the ready signal is seen, and the following cycle is a hit. Because the cache stalls the whole pipeline while it refills, its memory traffic never overlaps with the data cache's.

Fetch addresses that are not word-aligned are reported on a separate output and never cause a memory request. An invalid-address indication from memory is accepted as an input but has no effect.

Top module: `line_icache`

## Requirements
- R1: Reset clears the valid flag. After reset, any aligned fetch is a miss: memReq and stallOut are both 1.
- R2: memLineAddr always equals fetchAddr[31:4].
- R3: On an aligned miss, memReq and stallOut are both 1. They stay 1 in every cycle in which memValid is 0 and the address is unchanged.
- R4: When memValid is 1 while memReq is 1, the 128-bit memLine is stored with tag fetchAddr[31:4]. In the next cycle, with the same address, memReq and stallOut are 0 and instrOut carries the selected word.
- R5: fetchAddr[3:2] = k selects line bits [32k+31:32k] onto instrOut, with word 0 in bits 31:0. The selection happens without a memory request when the line is present.
- R6: A hit requires the valid flag and a tag equal to fetchAddr[31:4]. An address in a different line is a miss, even when the cache holds a valid line.
- R7: misalignOut is 1 exactly when fetchAddr[1:0] is not 0. Such a fetch never raises memReq or stallOut.
- R8: memBadAddr has no effect on any output.
- R9: memValid while memReq is 0 leaves the stored line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high; empties the cache |
| fetchAddr | input | 32 | Byte address of the requested instruction |
| instrOut | output | 32 | Selected word of the stored line |
| stallOut | output | 1 | Freezes the pipeline while a refill is outstanding |
| misalignOut | output | 1 | Fetch address is not word-aligned |
| memReq | output | 1 | Line read request to memory |
| memLineAddr | output | 28 | Line address sent to memory (fetchAddr[31:4]) |
| memLine | input | 128 | Line data returned by memory |
| memValid | input | 1 | Memory marks memLine as valid |
| memBadAddr | input | 1 | Invalid-address flag from memory (ignored) |

## Verification
The lookup is driven with several address patterns:
- All four word offsets within one cached line, which separates correct word selection from a stuck or swapped offset.
- An address in a different line after a valid fill, which separates a real tag compare from a check of the valid flag alone.
- A refill held back for several cycles, which shows that the request and the stall are held rather than pulsed.
- Misaligned addresses, both inside and outside the cached line, which show that they are flagged and never reach memory.
- A ready pulse from memory with no request outstanding, and the invalid-address input toggled, which show that neither disturbs the stored line or the outputs.

// File: rtl/lic_pkg.sv
package lic_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic fill;  // capture memLine, load tag, set valid
    logic busy;  // an aligned miss is outstanding
  } lic_strobe_t;
endpackage

// File: rtl/lic_datapath.sv
module lic_datapath
  import lic_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  lic_strobe_t               strb,
  input  logic [ADDR_W-1:0]         fetchAddr,
  input  logic [WORD_W*WORDS-1:0]   memLine,
  output logic                      hit,
  output logic                      misaligned,
  output logic [WORD_W-1:0]         instr
);
  localparam int LINE_W = WORD_W * WORDS;
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int SEL_W  = $clog2(WORDS);
  localparam int OFFS_W = BYTE_W + SEL_W;
  localparam int TAG_W  = ADDR_W - OFFS_W;

  logic              validQ;
  logic [TAG_W-1:0]  tagQ;
  logic [LINE_W-1:0] lineQ;
  logic [WORD_W-1:0] wordArr [WORDS];

  always_ff @(posedge clk) begin
    if (rst)            validQ <= 1'b0;
    else if (strb.fill) validQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst && strb.fill) begin
      tagQ  <= fetchAddr[ADDR_W-1:OFFS_W];
      lineQ <= memLine;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : gWord
    assign wordArr[g] = lineQ[g*WORD_W +: WORD_W];
  end

  assign hit        = validQ && (tagQ == fetchAddr[ADDR_W-1:OFFS_W]);
  assign misaligned = |fetchAddr[BYTE_W-1:0];
  assign instr      = wordArr[fetchAddr[OFFS_W-1:BYTE_W]];

  // R4
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    strb.fill |=> validQ);

  // R9
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (validQ && !strb.fill) |=> $stable(lineQ));

  // R6
  busy_only_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
    strb.busy |-> !hit);
endmodule

// File: rtl/lic_control.sv
module lic_control
  import lic_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        hit,
  input  logic        misaligned,
  input  logic        memValid,
  output lic_strobe_t strb,
  output logic        memReq,
  output logic        stallOut
);
  logic miss;

  assign miss      = !hit && !misaligned;
  assign strb.busy = miss;
  assign strb.fill = miss && memValid;
  assign memReq    = miss;
  assign stallOut  = miss;

  // R7
  misalign_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (!memReq && !stallOut));

  // R4
  hit_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> !memReq);
endmodule

// File: rtl/line_icache.sv
module line_icache
  import lic_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int LINE_W = WORD_W * WORDS,
  localparam int OFFS_W = $clog2(LINE_W / 8),
  localparam int TAG_W  = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [WORD_W-1:0] instrOut,
  output logic              stallOut,
  output logic              misalignOut,
  output logic              memReq,
  output logic [TAG_W-1:0]  memLineAddr,
  input  logic [LINE_W-1:0] memLine,
  input  logic              memValid,
  input  logic              memBadAddr
);
  lic_strobe_t strb;
  logic        hitW;
  logic        misW;

  lic_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .fetchAddr(fetchAddr),
    .memLine(memLine), .hit(hitW), .misaligned(misW), .instr(instrOut)
  );

  lic_control uCtl (
    .clk(clk), .rst(rst), .hit(hitW), .misaligned(misW),
    .memValid(memValid), .strb(strb), .memReq(memReq), .stallOut(stallOut)
  );

  assign misalignOut = misW;
  assign memLineAddr = fetchAddr[ADDR_W-1:OFFS_W];

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memValid) |=> (memReq || fetchAddr != $past(fetchAddr)));

  // R4
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && memValid) |=> (!memReq || fetchAddr != $past(fetchAddr)));

  // R8
  bad_addr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (memBadAddr && !hitW && !misW) |-> memReq);
endmodule

// File: tb/tb_line_icache.sv
module tb_line_icache;
  logic         clk = 1'b0;
  logic         rst;
  logic [31:0]  fetchAddr;
  logic [31:0]  instrOut;
  logic         stallOut, misalignOut, memReq;
  logic [27:0]  memLineAddr;
  logic [127:0] memLine;
  logic         memValid, memBadAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  line_icache dut (
    .clk(clk), .rst(rst), .fetchAddr(fetchAddr), .instrOut(instrOut),
    .stallOut(stallOut), .misalignOut(misalignOut), .memReq(memReq),
    .memLineAddr(memLineAddr), .memLine(memLine), .memValid(memValid),
    .memBadAddr(memBadAddr)
  );

  function automatic logic [127:0] mkLine(input logic [31:0] s);
    return {s + 32'd3, s + 32'd2, s + 32'd1, s};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, settle, then sample combinational outputs
  task automatic setAddr(input logic [31:0] a);
    @(negedge clk);
    fetchAddr = a;
    memValid  = 1'b0;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; memValid = 1'b0; memBadAddr = 1'b0; fetchAddr = 32'h0000_0100;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  // one cycle of memValid with line data, then settle in the next cycle
  task automatic deliver(input logic [127:0] l);
    @(negedge clk);
    memLine  = l;
    memValid = 1'b1;
    @(negedge clk);
    memValid = 1'b0;
    memLine  = '0;
    #1;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 memReq after reset", {31'd0, memReq}, 32'd1);
    chk("R1 stall after reset", {31'd0, stallOut}, 32'd1);
    chk("R2 line address", {4'd0, memLineAddr}, 32'h10);
  endtask

  task automatic t_wait_fill();
    setAddr(32'h0000_0100);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R3 request held", {31'd0, memReq}, 32'd1);
      chk("R3 stall held", {31'd0, stallOut}, 32'd1);
    end
    deliver(mkLine(32'hA000_0000));
    chk("R4 request dropped", {31'd0, memReq}, 32'd0);
    chk("R4 stall dropped", {31'd0, stallOut}, 32'd0);
    chk("R4 instruction", instrOut, 32'hA000_0000);
  endtask

  task automatic t_words();
    for (int k = 0; k < 4; k++) begin
      setAddr(32'h0000_0100 + 32'(k * 4));
      chk("R5 word select", instrOut, 32'hA000_0000 + 32'(k));
      chk("R5 no request", {31'd0, memReq}, 32'd0);
    end
  endtask

  task automatic t_tag();
    setAddr(32'h0000_0208);
    chk("R6 other line misses", {31'd0, memReq}, 32'd1);
    chk("R2 line address", {4'd0, memLineAddr}, 32'h20);
    deliver(mkLine(32'hB000_0010));
    chk("R4 new line word2", instrOut, 32'hB000_0012);
    setAddr(32'h0000_0100);
    chk("R6 old line evicted", {31'd0, memReq}, 32'd1);
  endtask

  task automatic t_misalign();
    setAddr(32'h0000_0201);
    chk("R7 misalign flag", {31'd0, misalignOut}, 32'd1);
    chk("R7 no request", {31'd0, memReq}, 32'd0);
    setAddr(32'h0000_0302);
    chk("R7 misalign uncached", {31'd0, misalignOut}, 32'd1);
    chk("R7 no request uncached", {31'd0, memReq}, 32'd0);
    chk("R7 no stall uncached", {31'd0, stallOut}, 32'd0);
    setAddr(32'h0000_0204);
    chk("R7 aligned clear", {31'd0, misalignOut}, 32'd0);
  endtask

  task automatic t_badaddr();
    setAddr(32'h0000_020C);
    memBadAddr = 1'b1;
    @(negedge clk); #1;
    chk("R8 hit unaffected", instrOut, 32'hB000_0013);
    chk("R8 no request on hit", {31'd0, memReq}, 32'd0);
    setAddr(32'h0000_0400);
    chk("R8 miss still requests", {31'd0, memReq}, 32'd1);
    chk("R8 no misalign", {31'd0, misalignOut}, 32'd0);
    memBadAddr = 1'b0;
  endtask

  task automatic t_spurious();
    setAddr(32'h0000_0204);
    @(negedge clk);
    memLine  = mkLine(32'hC000_0000);
    memValid = 1'b1;
    @(negedge clk);
    memValid = 1'b0;
    #1;
    chk("R9 line unchanged", instrOut, 32'hB000_0011);
    chk("R9 still hit", {31'd0, memReq}, 32'd0);
  endtask

  task automatic t_reset_again();
    doReset();
    fetchAddr = 32'h0000_0204;
    #1;
    chk("R1 reset empties line", {31'd0, memReq}, 32'd1);
  endtask

  initial begin
    rst = 1'b1; fetchAddr = '0; memLine = '0; memValid = 1'b0; memBadAddr = 1'b0;
    t_reset();
    t_wait_fill();
    t_words();
    t_tag();
    t_misalign();
    t_badaddr();
    t_spurious();
    t_reset_again();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule